// File: doc/BRIEF.md
# Cycle Timestamp Counter with Torn-Read Detection

The block keeps a free-running cycle counter that is wider than the register word. Software reaches it through three registers on a simple address-decoded bus: a control word, the lower word of the count and the upper word of the count. Software sets the run bit in the control word to start the count and clears it to freeze the count. The counter keeps its value while it is frozen.

A wide value cannot be read in one access, so software reads the lower word first, then the upper word, then the control word. The top bit of the control word tells software whether the two words belong together. The block sets an internal consistency flag on each lower-word read. It clears the flag when the lower word wraps into the upper word before the next control read. When software sees the flag clear, it repeats the sequence.

Read data is registered and appears one cycle after the read strobe, with a valid pulse. The counter width, the word width, the address width and the three register addresses are parameters.

Top module: `cstamp_aux`

## Requirements
- R1: Synchronous active-high reset clears the count, the run bit and the consistency flag. After reset, reads of all three registers return zero.
- R2: A write to the control address with data bit 0 at 1 sets the run bit. From the next cycle on, the count increases by exactly one per clock.
- R3: A write to the control address with data bit 0 at 0 clears the run bit. The count then holds its value.
- R4: A read of the lower-word address returns bits WORD_W-1..0 of the count as it stood at the clock edge that sampled the read.
- R5: A read of the upper-word address returns the count bits above WORD_W-1, zero-extended, as they stood at the sampling edge.
- R6: A read of the control address returns the run bit in bit 0 and the consistency flag in bit WORD_W-1. All other bits read as zero.
- R7: A lower-word read sets the consistency flag to 1. If the lower word wraps at that same edge, the flag is cleared instead.
- R8: A wrap of the lower word into the upper word clears the consistency flag. Writes do not change the flag.
- R9: Reads of unmapped addresses return zero. Writes to any address other than the control address leave the count and the run bit unchanged.
- R10: The read-valid output is high in exactly the cycle after each read strobe, and it holds the read data for that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |

## Verification
Each read result is due one clock after its strobe is sampled. It reflects the count and flag values from before that edge. A run-bit write first affects counting one edge later than the write itself. The bench drives strobes on falling edges and keeps a behavioural model that advances on every rising edge. It compares data and valid on the next falling edge, so each result is checked in the cycle it is due. The wrap cases are timed from the model's count: a wrap before the upper read, a wrap at the same edge as the lower read, and a wrap at the upper read's edge. This places each one on the exact edge that matters.

// File: rtl/cstamp_pkg.sv
package cstamp_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_LO   = 2'd2,
    SEL_HI   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cstamp_decode.sv
module cstamp_decode
  import cstamp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h103,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 'h104,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 'h105
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == CTRL_ADDR)    sel = SEL_CTRL;
    else if (addr == LO_ADDR) sel = SEL_LO;
    else if (addr == HI_ADDR) sel = SEL_HI;
    else                      sel = SEL_NONE;
  end
endmodule

// File: rtl/cstamp_counter.sv
module cstamp_counter #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  assign wrap = run & (&cnt_q[WORD_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cstamp_tear_track.sv
module cstamp_tear_track (
  input  logic clk,
  input  logic rst,
  input  logic lo_read,
  input  logic wrap,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (lo_read) flag_q <= ~wrap;
    else if (wrap)    flag_q <= 1'b0;
  end
endmodule

// File: rtl/cstamp_aux.sv
module cstamp_aux
  import cstamp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 64,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h103,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 'h104,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 'h105
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int unsigned HI_W = CNT_W - WORD_W;

  reg_sel_e          sel;
  logic              run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wrap;
  logic              flag_q;
  logic [WORD_W-1:0] hi_word;
  logic [WORD_W-1:0] ctrl_word;
  logic [WORD_W-1:0] rd_mux;

  cstamp_decode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  cstamp_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .run   (run_q),
    .cnt_q (cnt_q),
    .wrap  (wrap)
  );

  cstamp_tear_track u_tear (
    .clk     (clk),
    .rst     (rst),
    .lo_read (bus_rd && sel == SEL_LO),
    .wrap    (wrap),
    .flag_q  (flag_q)
  );

  generate
    if (HI_W < WORD_W) begin : g_hi_pad
      assign hi_word = {{(WORD_W-HI_W){1'b0}}, cnt_q[CNT_W-1:WORD_W]};
    end else begin : g_hi_full
      assign hi_word = cnt_q[CNT_W-1:WORD_W];
    end
  endgenerate

  assign ctrl_word = {flag_q, {(WORD_W-2){1'b0}}, run_q};

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = ctrl_word;
      SEL_LO:   rd_mux = cnt_q[WORD_W-1:0];
      SEL_HI:   rd_mux = hi_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      if (bus_wr && sel == SEL_CTRL) run_q <= bus_wdata[0];
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cstamp_aux_chk.sv
module cstamp_aux_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 64,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h103,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 'h104,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 'h105
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              flag_q
);
  logic lo_hit, mapped, low_full;
  assign lo_hit   = bus_rd && bus_addr == LO_ADDR;
  assign mapped   = bus_addr == CTRL_ADDR || bus_addr == LO_ADDR || bus_addr == HI_ADDR;
  assign low_full = run_q && (cnt_q[WORD_W-1:0] == {WORD_W{1'b1}});

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    run_q |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> cnt_q == $past(cnt_q));
  a_r6_ctrl_spare_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == CTRL_ADDR) |=> bus_rdata[WORD_W-2:1] == '0);
  a_r7_lo_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (lo_hit && !low_full) |=> flag_q);
  a_r8_wrap_clears: assert property (@(posedge clk) disable iff (rst)
    low_full |=> !flag_q);
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> bus_rdata == '0);
  a_r10_valid_after_rd: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  a_r10_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
endmodule

bind cstamp_aux cstamp_aux_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W),
  .CTRL_ADDR(CTRL_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .run_q      (run_q),
  .cnt_q      (cnt_q),
  .flag_q     (flag_q)
);

// File: tb/test_cstamp_aux.sv
module test_cstamp_aux;
  localparam int W = 8;
  localparam int C = 16;
  localparam int LOMOD = 1 << W;
  localparam int CMOD  = 1 << C;
  localparam logic [11:0] A_CTRL = 12'h103;
  localparam logic [11:0] A_LO   = 12'h104;
  localparam logic [11:0] A_HI   = 12'h105;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         bus_rvalid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference state
  int    m_cnt = 0;
  bit    m_run = 0;
  bit    m_flag = 0;
  int    m_data = 0;
  bit    m_valid = 0;
  string m_tag = "R10";

  always #10 clk = ~clk;

  cstamp_aux #(.ADDR_W(12), .WORD_W(W), .CNT_W(C)) i_cstamp_aux (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = 0; m_run = 0; m_flag = 0; m_data = 0; m_valid = 0; m_tag = "R1";
    end else begin
      bit wrapping;
      bit next_run;
      wrapping = m_run && (m_cnt % LOMOD == LOMOD - 1);
      next_run = m_run;
      m_valid = bus_rd;
      if (bus_rd) begin
        if (bus_addr == A_CTRL)    begin m_data = (int'(m_flag) << (W-1)) | int'(m_run); m_tag = "R6"; end
        else if (bus_addr == A_LO) begin m_data = m_cnt % LOMOD; m_tag = "R4"; end
        else if (bus_addr == A_HI) begin m_data = m_cnt / LOMOD; m_tag = "R5"; end
        else                       begin m_data = 0; m_tag = "R9"; end
      end
      if (bus_rd && bus_addr == A_LO) m_flag = !wrapping;
      else if (wrapping)              m_flag = 0;
      if (bus_wr && bus_addr == A_CTRL) next_run = bus_wdata[0];
      if (m_run) m_cnt = (m_cnt + 1) % CMOD;
      m_run = next_run;
    end
  end

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      chk(bus_rvalid == m_valid, "R10", int'(bus_rvalid), int'(m_valid));
      if (m_valid) chk(int'(bus_rdata) == m_data, m_tag, int'(bus_rdata), m_data);
    end
  end

  task automatic rd_op(input logic [11:0] a, output int d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = int'(bus_rdata);
    bus_rd = 1'b0;
  endtask

  task automatic wr_op(input logic [11:0] a, input int v);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v[W-1:0];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_low(input int v);
    while (m_cnt % LOMOD != v) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d, hi0, e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_op(A_CTRL, d); chk(d == 0, "R1", d, 0);
    rd_op(A_LO, d);   chk(d == 0, "R1", d, 0);
    rd_op(A_HI, d);   chk(d == 0, "R1", d, 0);

    // R2 start counting
    wr_op(A_CTRL, 1);
    repeat (5) @(negedge clk);
    e = m_cnt;
    rd_op(A_LO, d); chk(d == e % LOMOD, "R2", d, e % LOMOD);

    // R7 consistent sample
    wait_low(8'h10); hi0 = m_cnt / LOMOD;
    rd_op(A_LO, d);   chk(d == 8'h10, "R4", d, 8'h10);
    rd_op(A_HI, d);   chk(d == hi0, "R5", d, hi0);
    rd_op(A_CTRL, d); chk(d == 8'h81, "R7", d, 8'h81);

    // R8 wrap between lower and upper read: torn sample flagged
    wait_low(8'hfd); hi0 = m_cnt / LOMOD;
    rd_op(A_LO, d);   chk(d == 8'hfd, "R4", d, 8'hfd);
    repeat (4) @(negedge clk);
    rd_op(A_HI, d);   chk(d == (hi0 + 1) % LOMOD, "R5", d, (hi0 + 1) % LOMOD);
    rd_op(A_CTRL, d); chk(d == 8'h01, "R8", d, 8'h01);

    // R7 wrap at the same edge as the lower read
    wait_low(8'hff); hi0 = m_cnt / LOMOD;
    rd_op(A_LO, d);   chk(d == 8'hff, "R4", d, 8'hff);
    rd_op(A_HI, d);   chk(d == (hi0 + 1) % LOMOD, "R5", d, (hi0 + 1) % LOMOD);
    rd_op(A_CTRL, d); chk(d == 8'h01, "R7", d, 8'h01);

    // R8 wrap at the upper read's edge still clears the flag
    wait_low(8'hfe); hi0 = m_cnt / LOMOD;
    rd_op(A_LO, d);   chk(d == 8'hfe, "R4", d, 8'hfe);
    rd_op(A_HI, d);   chk(d == hi0, "R5", d, hi0);
    rd_op(A_CTRL, d); chk(d == 8'h01, "R8", d, 8'h01);

    // R3 freeze via control write with other bits set
    wr_op(A_CTRL, 8'hfe);
    repeat (2) @(negedge clk);
    e = m_cnt;
    repeat (10) @(negedge clk);
    rd_op(A_LO, d); chk(d == e % LOMOD, "R3", d, e % LOMOD);

    // R9 writes elsewhere ignored, unmapped read is zero
    wr_op(A_LO, 8'h55);
    wr_op(A_HI, 8'h55);
    wr_op(12'h106, 8'h01);
    rd_op(A_LO, d);    chk(d == e % LOMOD, "R9", d, e % LOMOD);
    rd_op(A_HI, d);    chk(d == e / LOMOD, "R9", d, e / LOMOD);
    rd_op(12'h106, d); chk(d == 0, "R9", d, 0);
    rd_op(A_CTRL, d);  chk(d == 8'h80, "R6", d, 8'h80);

    // R2 rerun across many wraps with back-to-back sequences
    wr_op(A_CTRL, 1);
    for (int i = 0; i < 300; i++) begin
      rd_op(A_LO, d);
      rd_op(A_HI, d);
      rd_op(A_CTRL, d);
      if (i % 3 == 0) @(negedge clk);
    end

    // R1 reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd_op(A_CTRL, d); chk(d == 0, "R1", d, 0);
    rd_op(A_LO, d);   chk(d == 0, "R1", d, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule